// File: doc/BRIEF.md
# Two-State Branch-Exchange PC Sequencer

This block sits in the fetch stage of a processor core that runs two instruction-set states: a wide state with 32-bit instructions and a compact state with 16-bit instructions. It holds the fetch program counter and a one-bit state flag. On each advance strobe it steps the PC to the next instruction. It also carries out register-indirect branches that may switch state. In a branch target, the lowest bit is not an address bit. It selects the state to run next, and the fetch address is the target with that bit cleared.

For a branch that also links, the block produces a link value: the return address, with its lowest bit set to the state that was active before the branch. A later exchange branch through that value therefore returns to the caller in the caller's own state. A target whose lowest bit is clear but whose bit 1 is set would put wide-state code on an address that is 2 modulo 4. Such a target raises a sticky alignment fault and changes nothing else. Decode, the register file and memory lie outside the block. The length hint marks a compact-state instruction that occupies two halfwords.

Top module: `iw_pc_sequencer`

## Requirements
- R1: While reset is active and on the first cycle after it, pc_o is 0, compact_o is 0 (wide state), align_fault_o is 0 and lr_we_o is 0.
- R2: An accepted branch copies bit 0 of br_target_i into compact_o on the next cycle: 1 selects the compact state and 0 selects the wide state.
- R3: After an accepted branch, pc_o equals br_target_i with bit 0 forced to 0. A target of 1 gives the compact state at address 0, and a target of 3 gives the compact state at address 2. In the wide state, pc_o[1:0] is always 0.
- R4: A branch target with bit 0 = 0 and bit 1 = 1 is refused. On the next cycle align_fault_o is 1, pc_o and compact_o are unchanged, and lr_we_o is 0.
- R5: align_fault_o stays 1 through advance strobes and idle cycles. Only the next accepted branch or a reset clears it.
- R6: With no branch request, an advance strobe adds 4 to pc_o in the wide state. In the compact state it adds 2, or 4 when long_hint_i is 1. In the wide state long_hint_i has no effect. The PC wraps modulo 2^ADDR_W.
- R7: For an accepted branch with br_link_i = 1, lr_data_o equals the return address (the pre-branch pc_o plus the R6 step for that cycle's state and hint), with bit 0 replaced by the pre-branch compact_o.
- R8: lr_we_o is 1 for exactly the one cycle that follows an accepted branch with br_link_i = 1, and is 0 at every other time.
- R9: When br_req_i and advance_i are both 1, only the branch takes effect. The advance step is not applied.
- R10: An exchange branch to the R7 link value restores the caller's state flag and resumes at the caller's return address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| advance_i | input | 1 | Step to the next sequential instruction |
| br_req_i | input | 1 | Register-indirect branch request |
| br_link_i | input | 1 | 1: branch-link-exchange, 0: branch-exchange |
| br_target_i | input | ADDR_W | Target register value; bit 0 selects the state |
| long_hint_i | input | 1 | Current compact instruction is 4 bytes long |
| pc_o | output | ADDR_W | Fetch program counter |
| compact_o | output | 1 | State flag: 1 compact, 0 wide |
| lr_data_o | output | ADDR_W | Link value to write |
| lr_we_o | output | 1 | Link register write enable |
| align_fault_o | output | 1 | Sticky alignment fault |

## Verification
Every result of this block is registered once. The PC, the state flag, the fault flag and the link pair all change on the first rising edge after the cycle that presents the request or strobe, and none of them lags further. The bench drives each stimulus at a falling edge, waits for the next rising edge, and samples one time unit later. It then compares every output with a model that it advances by one step for that same edge. Targets are swept over the whole address range of an 8-bit instance, for both branch kinds and both starting states, and every accepted link branch is followed by a return through the link value.

// File: rtl/iw_pkg.sv
package iw_pkg;

   typedef enum logic {
      ISA_WIDE    = 1'b0,
      ISA_COMPACT = 1'b1
   } isa_e;

   localparam int unsigned WIDE_BYTES = 4;
   localparam int unsigned HALF_BYTES = 2;

endpackage

// File: rtl/iw_step_calc.sv
module iw_step_calc
   import iw_pkg::*;
#(
   parameter int unsigned ADDR_W          = 32,
   parameter bit          LONG_COMPACT_EN = 1'b1
) (
   input  isa_e              state_i,
   input  logic              long_hint_i,
   input  logic [ADDR_W-1:0] pc_i,
   output logic [ADDR_W-1:0] next_pc_o
);

   localparam logic [ADDR_W-1:0] STEP_WIDE = ADDR_W'(WIDE_BYTES);
   localparam logic [ADDR_W-1:0] STEP_HALF = ADDR_W'(HALF_BYTES);

   logic [ADDR_W-1:0] step;

   generate
      if (LONG_COMPACT_EN) begin : g_long_compact
         always_comb begin
            if (state_i == ISA_WIDE || long_hint_i) step = STEP_WIDE;
            else                                    step = STEP_HALF;
         end
      end else begin : g_half_only
         logic unused_hint;
         assign unused_hint = long_hint_i;
         always_comb begin
            if (state_i == ISA_WIDE) step = STEP_WIDE;
            else                     step = STEP_HALF;
         end
      end
   endgenerate

   assign next_pc_o = pc_i + step;

   always_comb begin
      assert_step_even_R6 : assert (next_pc_o[0] == pc_i[0]);
   end

endmodule

// File: rtl/iw_target_decode.sv
module iw_target_decode
   import iw_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] target_i,
   output isa_e              state_o,
   output logic [ADDR_W-1:0] dest_o,
   output logic              misalign_o
);

   assign state_o    = isa_e'(target_i[0]);
   assign dest_o     = {target_i[ADDR_W-1:1], 1'b0};
   assign misalign_o = ~target_i[0] & target_i[1];

endmodule

// File: rtl/iw_link_gen.sv
module iw_link_gen
   import iw_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] ret_addr_i,
   input  isa_e              caller_i,
   output logic [ADDR_W-1:0] link_o
);

   assign link_o = {ret_addr_i[ADDR_W-1:1], caller_i};

endmodule

// File: rtl/iw_pc_sequencer.sv
module iw_pc_sequencer
   import iw_pkg::*;
#(
   parameter int unsigned      ADDR_W          = 32,
   parameter bit               LONG_COMPACT_EN = 1'b1,
   parameter logic [63:0]      RESET_PC        = 64'd0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              advance_i,
   input  logic              br_req_i,
   input  logic              br_link_i,
   input  logic [ADDR_W-1:0] br_target_i,
   input  logic              long_hint_i,
   output logic [ADDR_W-1:0] pc_o,
   output logic              compact_o,
   output logic [ADDR_W-1:0] lr_data_o,
   output logic              lr_we_o,
   output logic              align_fault_o
);

   localparam logic [ADDR_W-1:0] PC_RST = RESET_PC[ADDR_W-1:0];

   generate
      if (ADDR_W < 4 || ADDR_W > 64) begin : g_bad_width
         $error("iw_pc_sequencer: ADDR_W must lie in 4..64");
      end
      if (RESET_PC[1:0] != 2'b00) begin : g_bad_reset
         $error("iw_pc_sequencer: RESET_PC must be 4-byte aligned");
      end
   endgenerate

   logic [ADDR_W-1:0] pc_q;
   isa_e              state_q;
   logic              fault_q;
   logic              lr_we_q;
   logic [ADDR_W-1:0] lr_data_q;

   logic [ADDR_W-1:0] seq_pc;
   isa_e              tgt_state;
   logic [ADDR_W-1:0] tgt_dest;
   logic              tgt_misalign;
   logic [ADDR_W-1:0] link_val;
   logic              br_accept;

   iw_step_calc #(
      .ADDR_W          (ADDR_W),
      .LONG_COMPACT_EN (LONG_COMPACT_EN)
   ) u_step (
      .state_i     (state_q),
      .long_hint_i (long_hint_i),
      .pc_i        (pc_q),
      .next_pc_o   (seq_pc)
   );

   iw_target_decode #(
      .ADDR_W (ADDR_W)
   ) u_decode (
      .target_i   (br_target_i),
      .state_o    (tgt_state),
      .dest_o     (tgt_dest),
      .misalign_o (tgt_misalign)
   );

   iw_link_gen #(
      .ADDR_W (ADDR_W)
   ) u_link (
      .ret_addr_i (seq_pc),
      .caller_i   (state_q),
      .link_o     (link_val)
   );

   assign br_accept = br_req_i & ~tgt_misalign;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         pc_q      <= PC_RST;
         state_q   <= ISA_WIDE;
         fault_q   <= 1'b0;
         lr_we_q   <= 1'b0;
         lr_data_q <= '0;
      end else begin
         lr_we_q <= 1'b0;
         if (br_req_i) begin
            if (tgt_misalign) begin
               fault_q <= 1'b1;
            end else begin
               pc_q    <= tgt_dest;
               state_q <= tgt_state;
               fault_q <= 1'b0;
               if (br_link_i) begin
                  lr_we_q   <= 1'b1;
                  lr_data_q <= link_val;
               end
            end
         end else if (advance_i) begin
            pc_q <= seq_pc;
         end
      end
   end

   assign pc_o          = pc_q;
   assign compact_o     = state_q;
   assign lr_data_o     = lr_data_q;
   assign lr_we_o       = lr_we_q;
   assign align_fault_o = fault_q;

   assert_even_pc_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      pc_q[0] == 1'b0);

   assert_wide_align_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ISA_WIDE) |-> (pc_q[1:0] == 2'b00));

   assert_fault_freeze_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (br_req_i && tgt_misalign) |=> ($stable(pc_q) && $stable(state_q) && fault_q && !lr_we_q));

   assert_fault_sticky_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fault_q && !br_req_i) |=> fault_q);

   assert_wide_step_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (advance_i && !br_req_i && state_q == ISA_WIDE) |=> (pc_q == $past(pc_q) + ADDR_W'(4)));

   assert_lr_source_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      lr_we_q |-> $past(br_accept && br_link_i));

   assert_branch_wins_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (br_accept && advance_i) |=> (pc_q == $past(tgt_dest)));

endmodule

// File: tb/sim_iw_pc_sequencer.sv
module sim_iw_pc_sequencer;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned AW         = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          advance = 1'b0;
   logic          br_req = 1'b0;
   logic          br_link = 1'b0;
   logic [AW-1:0] br_target = '0;
   logic          long_hint = 1'b0;
   logic [AW-1:0] pc;
   logic          compact;
   logic [AW-1:0] lr_data;
   logic          lr_we;
   logic          fault;

   int checks = 0;
   int errors = 0;

   logic [AW-1:0] m_pc = '0;
   logic          m_state = 1'b0;
   logic          m_fault = 1'b0;
   logic          m_we = 1'b0;
   logic [AW-1:0] m_lr = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   iw_pc_sequencer #(
      .ADDR_W          (AW),
      .LONG_COMPACT_EN (1'b1),
      .RESET_PC        (64'd0)
   ) u0 (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .advance_i     (advance),
      .br_req_i      (br_req),
      .br_link_i     (br_link),
      .br_target_i   (br_target),
      .long_hint_i   (long_hint),
      .pc_o          (pc),
      .compact_o     (compact),
      .lr_data_o     (lr_data),
      .lr_we_o       (lr_we),
      .align_fault_o (fault)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, "pc", int'(pc), int'(m_pc));
      chk(tag, "state", int'(compact), int'(m_state));
      chk(tag, "fault", int'(fault), int'(m_fault));
      chk(tag, "lr_we", int'(lr_we), int'(m_we));
      if (m_we) chk(tag, "lr_data", int'(lr_data), int'(m_lr));
   endtask

   task automatic cyc(input bit adv, input bit req, input bit lnk,
                      input logic [AW-1:0] tgt, input bit hint, input string tag);
      logic [AW-1:0] stp;
      @(negedge clk);
      advance = adv; br_req = req; br_link = lnk; br_target = tgt; long_hint = hint;
      stp  = (m_state && !hint) ? AW'(2) : AW'(4);
      m_we = 1'b0;
      if (req) begin
         if (!tgt[0] && tgt[1]) begin
            m_fault = 1'b1;
         end else begin
            if (lnk) begin
               m_we = 1'b1;
               m_lr = (m_pc + stp) | {{(AW-1){1'b0}}, m_state};
            end
            m_pc    = tgt & ~AW'(1);
            m_state = tgt[0];
            m_fault = 1'b0;
         end
      end else if (adv) begin
         m_pc = m_pc + stp;
      end
      @(posedge clk);
      #1;
      check_all(tag);
      advance = 0; br_req = 0; br_link = 0; long_hint = 0;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : stim
      logic [AW-1:0] ret_pc;
      logic          ret_st;
      repeat (3) @(posedge clk);
      #1;
      check_all("R1 in reset");
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check_all("R1 after reset");

      // R6 wide steps, hint ignored in wide state
      cyc(1, 0, 0, '0, 0, "R6 wide");
      cyc(1, 0, 0, '0, 1, "R6 wide hint");
      // R3 named targets 1 and 3
      cyc(0, 1, 0, AW'(1), 0, "R3 target1");
      cyc(0, 1, 0, AW'(3), 0, "R3 target3");
      cyc(1, 0, 0, '0, 0, "R6 compact");
      cyc(1, 0, 0, '0, 1, "R6 compact long");
      // R4 / R5 fault then sticky across advances
      cyc(0, 1, 1, AW'(2), 0, "R4 fault");
      cyc(1, 0, 0, '0, 0, "R5 sticky adv");
      cyc(0, 0, 0, '0, 0, "R5 sticky idle");
      cyc(0, 1, 0, AW'(8), 0, "R5 clear");
      // R9 priority
      cyc(1, 1, 0, AW'(21), 0, "R9 priority");
      cyc(1, 1, 1, AW'(6), 0, "R9 priority fault");
      // R6 wrap
      cyc(0, 1, 0, AW'(253), 0, "R6 wrap setup");
      cyc(1, 0, 0, '0, 1, "R6 wrap");

      for (int t = 0; t < (1 << AW); t++) begin
         for (int k = 0; k < 2; k++) begin
            for (int s = 0; s < 2; s++) begin
               logic [AW-1:0] tv;
               tv = AW'(t);
               cyc(0, 1, 0, AW'(s * 41), 0, "R2 setup");
               cyc(1, 0, 0, '0, bit'(t & 4), "R6 sweep");
               ret_pc = m_pc; ret_st = m_state;
               if (!tv[0] && tv[1])
                  cyc(1, 1, k[0], tv, bit'(t & 8), "R4 sweep");
               else if (k == 1)
                  cyc(0, 1, 1, tv, bit'(t & 8), "R7 R8 sweep");
               else
                  cyc(0, 1, 0, tv, 0, "R2 R3 sweep");
               if (k == 1 && !(!tv[0] && tv[1])) begin
                  cyc(0, 0, 0, '0, 0, "R8 single pulse");
                  cyc(0, 1, 0, m_lr, 0, "R10 return");
                  chk("R10 state", "state", int'(compact), int'(ret_st));
                  chk("R10 addr", "pc", int'(pc), int'(ret_pc + ((ret_st && !bit'(t & 8)) ? 2 : 4)) & 8'hFF);
               end
            end
         end
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule